// File: doc/BRIEF.md
# Lifting-Based Four-Tap Daubechies Wavelet Stage

This block is one pipelined 1-D analysis stage of a four-tap Daubechies wavelet, computed as a chain of lifting steps rather than as a pair of convolution filters. Each valid cycle it takes one sample pair: the even-indexed sample x(2n) and the odd-indexed sample x(2n+1), both signed fixed-point. After a fixed latency it returns one low-pass and one high-pass coefficient. Scale normalisation by K and 1/K is not done here. A downstream block applies it, so both outputs leave unnormalised.

There are three lifting steps. The predict step forms d1[n] = x(2n+1) + a*x(2n) with a = -sqrt(3). The update step forms s1[n] = x(2n) + b*d1[n] + c*d1[n-1] with b = sqrt(3)/4 and c = (sqrt(3)-2)/4. The final step forms d2[n] = d1[n] + s1[n+1]. The outputs are low = s1[n] and high = d2[n].

The look-ahead term s1[n+1] is obtained by holding pair n back for one valid pair. A line-start flag on the first pair of each line does two things:
- It seeds the delayed d1 term by mirroring that first pair.
- It completes the held last pair of the previous line by mirroring that pair's own s1.

Top module: `d4_lift_stage`

## Requirements
- R1: After reset, out_valid and out_first are 0 and stay 0 until pair data has entered the stage.
- R2: The predict step computes d1 = odd + a*even. The constant a is -28378 in Q2.14, and the rounded product is added to the odd sample.
- R3: The update step computes low = s1[n] = even + b*d1[n] + c*d1[n-1]. The constants are b = 7094 and c = -1098 in Q2.14, and each product is rounded to nearest.
- R4: The high output computes high = d1[n] + s1[n+1], where s1[n+1] comes from the next pair of the same line.
- R5: For the pair carrying in_start = 1, the delayed term d1[n-1] is replaced by that pair's own d1.
- R6: When a pair with in_start = 1 arrives while an earlier pair is held, the held pair is emitted with s1[n+1] replaced by its own s1.
- R7: Every intermediate result and every output saturates to the signed DW-bit range (DW = 16: -32768 to 32767).
- R8: The coefficients of pair n appear with out_valid = 1 exactly 3 clock cycles after the cycle in which pair n+1 (or the next line's first pair) was presented with in_valid = 1. Cycles with in_valid = 0 do not change any coefficient value.
- R9: A pair produces no output while no later valid pair has arrived. A single pair after reset yields no out_valid pulse.
- R10: out_first = 1 exactly on the output of the first pair of each line, and only together with out_valid = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is presented this cycle |
| in_start | input | 1 | The presented pair is the first of a line |
| in_even | input | DW | Even-indexed sample x(2n), signed |
| in_odd | input | DW | Odd-indexed sample x(2n+1), signed |
| out_valid | output | 1 | out_low/out_high carry a coefficient pair |
| out_first | output | 1 | Coefficient pair belongs to the first pair of a line |
| out_low | output | DW | Unnormalised low-pass coefficient, signed |
| out_high | output | DW | Unnormalised high-pass coefficient, signed |

## Verification
The main function is driven with these inputs, each compared against a real-valued model of the same lifting chain that uses the quantised constants, to within 2 LSB:

- **Constant line:** shows that the b and c weights add up.
- **Ramp:** exposes a missing or swapped look-ahead term.
- **Alternating-sign pattern:** separates the weight on d1[n] from the weight on d1[n-1].
- **Even and odd impulses at the edge and in the middle of a line:** isolate each tap and the mirrored edge terms.
- **Large opposite-sign samples:** drive the predict step into both saturation limits.
- **One-pair line:** exercises both mirrors at once.
- **Line with bubbles:** checks that bubbles change neither values nor the 3-cycle emission timing.
- **Two back-to-back lines without reset:** check the line-start flush and the first-of-line flag.

// File: rtl/d4l_pkg.sv
package d4l_pkg;
  // Q2.14 lifting constants
  localparam int D4_FB = 14;
  localparam int D4_KA = -28378;  // -sqrt(3)
  localparam int D4_KB = 7094;    // sqrt(3)/4
  localparam int D4_KC = -1098;   // (sqrt(3)-2)/4

  // constant multiply with round-to-nearest back to integer scale
  function automatic longint rnd_mul(input longint x, input longint k, input int fb);
    longint p;
    p = x * k;
    return (p + (longint'(1) <<< (fb - 1))) >>> fb;
  endfunction

  // saturate to a signed w-bit range
  function automatic longint clip(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/d4l_predict.sv
module d4l_predict
  import d4l_pkg::*;
#(
  parameter int DW = 16,
  parameter int FB = D4_FB,
  parameter int KA = D4_KA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [DW-1:0] in_even,
  input  logic signed [DW-1:0] in_odd,
  output logic                 a_valid,
  output logic                 a_start,
  output logic signed [DW-1:0] a_even,
  output logic signed [DW-1:0] a_d1
);
  localparam logic signed [DW-1:0] D_HI = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_LO = {1'b1, {(DW-1){1'b0}}};

  longint pred_sum;
  logic signed [DW-1:0] d1_now;

  always_comb begin
    pred_sum = longint'(in_odd) + rnd_mul(longint'(in_even), longint'(KA), FB);
    d1_now   = DW'(clip(pred_sum, DW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_start <= 1'b0;
      a_even  <= '0;
      a_d1    <= '0;
    end else begin
      a_valid <= in_valid;
      a_start <= in_valid & in_start;
      if (in_valid) begin
        a_even <= in_even;
        a_d1   <= d1_now;
      end
    end
  end

  // R7: predict result pinned at the rails when the wide sum leaves the range
  assert_pred_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sum > longint'(D_HI)) |=> (a_d1 == D_HI));
  assert_pred_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sum < longint'(D_LO)) |=> (a_d1 == D_LO));
endmodule

// File: rtl/d4l_update.sv
module d4l_update
  import d4l_pkg::*;
#(
  parameter int DW = 16,
  parameter int FB = D4_FB,
  parameter int KB = D4_KB,
  parameter int KC = D4_KC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_valid,
  input  logic                 a_start,
  input  logic signed [DW-1:0] a_even,
  input  logic signed [DW-1:0] a_d1,
  output logic                 b_valid,
  output logic                 b_start,
  output logic signed [DW-1:0] b_s1,
  output logic signed [DW-1:0] b_d1
);
  logic signed [DW-1:0] d1_hist;   // d1 of the previous pair
  logic signed [DW-1:0] d1_prev;   // delayed term after edge mirroring
  longint upd_sum;
  logic signed [DW-1:0] s1_now;

  always_comb begin
    d1_prev = a_start ? a_d1 : d1_hist;
    upd_sum = longint'(a_even)
            + rnd_mul(longint'(a_d1), longint'(KB), FB)
            + rnd_mul(longint'(d1_prev), longint'(KC), FB);
    s1_now  = DW'(clip(upd_sum, DW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid <= 1'b0;
      b_start <= 1'b0;
      b_s1    <= '0;
      b_d1    <= '0;
      d1_hist <= '0;
    end else begin
      b_valid <= a_valid;
      b_start <= a_valid & a_start;
      if (a_valid) begin
        b_s1    <= s1_now;
        b_d1    <= a_d1;
        d1_hist <= a_d1;
      end
    end
  end

  // R5: on a line start the history register picks up the first pair's d1
  assert_hist_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_start) |=> (d1_hist == b_d1));
endmodule

// File: rtl/d4l_finish.sv
module d4l_finish
  import d4l_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 b_valid,
  input  logic                 b_start,
  input  logic signed [DW-1:0] b_s1,
  input  logic signed [DW-1:0] b_d1,
  output logic                 out_valid,
  output logic                 out_first,
  output logic signed [DW-1:0] out_low,
  output logic signed [DW-1:0] out_high
);
  logic                 hold_v;
  logic                 hold_start;
  logic signed [DW-1:0] hold_s1;
  logic signed [DW-1:0] hold_d1;
  logic signed [DW-1:0] s1_ahead;   // s1[n+1], mirrored at a line edge
  logic signed [DW-1:0] high_now;
  logic                 emit_now;

  always_comb begin
    s1_ahead = b_start ? hold_s1 : b_s1;
    high_now = DW'(clip(longint'(hold_d1) + longint'(s1_ahead), DW));
    emit_now = b_valid & hold_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_start <= 1'b0;
      hold_s1    <= '0;
      hold_d1    <= '0;
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_low    <= '0;
      out_high   <= '0;
    end else begin
      out_valid <= emit_now;
      out_first <= emit_now & hold_start;
      if (emit_now) begin
        out_low  <= hold_s1;
        out_high <= high_now;
      end
      if (b_valid) begin
        hold_v     <= 1'b1;
        hold_start <= b_start;
        hold_s1    <= b_s1;
        hold_d1    <= b_d1;
      end
    end
  end

  // R10: first-of-line flag only rides on a valid output
  assert_first_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  // R9: nothing emitted unless a pair was already held
  assert_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(hold_v));
endmodule

// File: rtl/d4_lift_stage.sv
module d4_lift_stage
  import d4l_pkg::*;
#(
  parameter int DW = 16,
  parameter int FB = D4_FB,
  parameter int KA = D4_KA,
  parameter int KB = D4_KB,
  parameter int KC = D4_KC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [DW-1:0] in_even,
  input  logic signed [DW-1:0] in_odd,
  output logic                 out_valid,
  output logic                 out_first,
  output logic signed [DW-1:0] out_low,
  output logic signed [DW-1:0] out_high
);
  logic                 a_valid, a_start, b_valid, b_start;
  logic signed [DW-1:0] a_even, a_d1, b_s1, b_d1;

  d4l_predict #(.DW(DW), .FB(FB), .KA(KA)) u_predict (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_even(in_even), .in_odd(in_odd),
    .a_valid(a_valid), .a_start(a_start), .a_even(a_even), .a_d1(a_d1));

  d4l_update #(.DW(DW), .FB(FB), .KB(KB), .KC(KC)) u_update (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_start(a_start),
    .a_even(a_even), .a_d1(a_d1),
    .b_valid(b_valid), .b_start(b_start), .b_s1(b_s1), .b_d1(b_d1));

  d4l_finish #(.DW(DW)) u_finish (
    .clk(clk), .rst_n(rst_n), .b_valid(b_valid), .b_start(b_start),
    .b_s1(b_s1), .b_d1(b_d1),
    .out_valid(out_valid), .out_first(out_first),
    .out_low(out_low), .out_high(out_high));

  // R8: an output pulse always follows a presented pair by three cycles
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));
  // R1: quiet right after reset release
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_first));
endmodule

// File: tb/d4_lift_stage_test.sv
module d4_lift_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_start = 1'b0;
  logic signed [15:0] in_even = '0;
  logic signed [15:0] in_odd = '0;
  logic out_valid, out_first;
  logic signed [15:0] out_low, out_high;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  int  sxe [64];
  int  sxo [64];
  bit  sst [64];
  int  dcyc [65];
  real exp_lo [64];
  real exp_hi [64];
  int  cap_lo [128];
  int  cap_hi [128];
  bit  cap_fi [128];
  int  cap_cy [128];
  int  ncap = 0;

  localparam real QA = -28378.0 / 16384.0;
  localparam real QB = 7094.0 / 16384.0;
  localparam real QC = -1098.0 / 16384.0;

  d4_lift_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
    .out_first(out_first), .out_low(out_low), .out_high(out_high));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (out_valid && ncap < 128) begin
      cap_lo[ncap] = int'(out_low);
      cap_hi[ncap] = int'(out_high);
      cap_fi[ncap] = out_first;
      cap_cy[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  function automatic real clampr(input real r);
    if (r > 32767.0) return 32767.0;
    if (r < -32768.0) return -32768.0;
    return r;
  endfunction

  // real-valued lifting model of one line at offset off
  task automatic model_line(input int off, input int len);
    real d1r [64];
    real s1r [64];
    for (int i = 0; i < len; i++)
      d1r[i] = clampr(real'(sxo[off+i]) + QA * real'(sxe[off+i]));
    for (int i = 0; i < len; i++)
      s1r[i] = clampr(real'(sxe[off+i]) + QB * d1r[i] + QC * ((i == 0) ? d1r[0] : d1r[i-1]));
    for (int i = 0; i < len; i++) begin
      exp_lo[off+i] = s1r[i];
      exp_hi[off+i] = clampr(d1r[i] + ((i == len - 1) ? s1r[i] : s1r[i+1]));
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input real expv);
    real d;
    checks++;
    d = real'(act) - expv;
    if (d < 0.0) d = -d;
    if (d > 2.0) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0.2f", req, what, act, expv);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    ncap = 0;
  endtask

  // drive total pairs with gap idle cycles between them, then a flushing line start
  task automatic drive_seq(input int total, input int gap);
    for (int i = 0; i < total; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b1; in_start = sst[i];
      in_even = 16'(sxe[i]); in_odd = 16'(sxo[i]);
      dcyc[i] = cyc;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
        in_valid = 1'b0; in_start = 1'b0;
      end
    end
    @(negedge clk); #1;
    in_valid = 1'b1; in_start = 1'b1; in_even = '0; in_odd = '0;
    dcyc[total] = cyc;
    @(negedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_outputs(input string req, input int total);
    chk_int(req, "output count", ncap, total);
    for (int i = 0; i < total && i < ncap; i++) begin
      chk_near(req, $sformatf("low[%0d]", i), cap_lo[i], exp_lo[i]);
      chk_near(req, $sformatf("high[%0d]", i), cap_hi[i], exp_hi[i]);
    end
  endtask

  task automatic run_line(input string req, input int len, input int gap);
    do_reset();
    for (int i = 0; i < len; i++) sst[i] = (i == 0);
    model_line(0, len);
    drive_seq(len, gap);
    check_outputs(req, len);
    if (ncap > 0) chk_int("R10", "first flag on pair 0", int'(cap_fi[0]), 1);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (5) @(negedge clk);
    chk_int("R1", "out_valid after reset", int'(out_valid), 0);
    chk_int("R1", "out_first after reset", int'(out_first), 0);
    chk_int("R1", "pulses after reset", ncap, 0);
  endtask

  task automatic t_constant();
    for (int i = 0; i < 6; i++) begin sxe[i] = 1000; sxo[i] = -500; end
    run_line("R3", 6, 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 8; i++) begin sxe[i] = 300 * i - 1000; sxo[i] = 300 * i - 850; end
    run_line("R4", 8, 0);
  endtask

  task automatic t_alternating();
    for (int i = 0; i < 8; i++) begin
      sxe[i] = (i % 2 == 0) ? 3000 : -3000;
      sxo[i] = (i % 2 == 0) ? -1200 : 1200;
    end
    run_line("R3", 8, 0);
  endtask

  task automatic t_even_impulse_edge();
    for (int i = 0; i < 6; i++) begin sxe[i] = 0; sxo[i] = 0; end
    sxe[0] = 4000;
    run_line("R5", 6, 0);
  endtask

  task automatic t_odd_impulse_mid();
    for (int i = 0; i < 7; i++) begin sxe[i] = 0; sxo[i] = 0; end
    sxo[3] = 5000;
    run_line("R2", 7, 0);
  endtask

  task automatic t_saturation();
    sxe[0] = 20000;  sxo[0] = -20000;
    sxe[1] = -20000; sxo[1] = 20000;
    sxe[2] = 20000;  sxo[2] = -20000;
    sxe[3] = 32000;  sxo[3] = -32000;
    run_line("R7", 4, 0);
  endtask

  task automatic t_single_pair();
    do_reset();
    sxe[0] = 2500; sxo[0] = 700; sst[0] = 1'b1;
    model_line(0, 1);
    @(negedge clk); #1;
    in_valid = 1'b1; in_start = 1'b1; in_even = 16'(sxe[0]); in_odd = 16'(sxo[0]);
    @(negedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0;
    repeat (6) @(negedge clk);
    chk_int("R9", "no output for lone pair", ncap, 0);
    @(negedge clk); #1;
    in_valid = 1'b1; in_start = 1'b1; in_even = '0; in_odd = '0;
    @(negedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0;
    repeat (6) @(negedge clk);
    check_outputs("R6", 1);
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      sxe[i] = 1500 - 700 * i; sxo[i] = 200 * i * i - 900; sst[i] = (i == 0);
    end
    model_line(0, 5);
    drive_seq(5, 2);
    check_outputs("R8", 5);
    for (int i = 0; i < 5 && i < ncap; i++)
      chk_int("R8", $sformatf("emission cycle of pair %0d", i), cap_cy[i], dcyc[i+1] + 3);
  endtask

  task automatic t_two_lines();
    do_reset();
    for (int i = 0; i < 7; i++) begin
      sxe[i] = (i < 4) ? 800 * i - 1200 : 2000 - 500 * i;
      sxo[i] = (i < 4) ? 400 - 300 * i : 150 * i;
      sst[i] = (i == 0) || (i == 4);
    end
    model_line(0, 4);
    model_line(4, 3);
    drive_seq(7, 0);
    check_outputs("R6", 7);
    for (int i = 0; i < 7 && i < ncap; i++)
      chk_int("R10", $sformatf("first flag [%0d]", i), int'(cap_fi[i]), (i == 0 || i == 4) ? 1 : 0);
  endtask

  initial begin
    t_reset();
    t_constant();
    t_ramp();
    t_alternating();
    t_even_impulse_edge();
    t_odd_impulse_mid();
    t_saturation();
    t_single_pair();
    t_gaps();
    t_two_lines();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule